// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a small, fully associative translation buffer. Each of its entries describes two neighbouring virtual pages, an even one and an odd one, that share one tag, one address-space identifier and one page size; each half carries its own physical frame and its own permission bits. A lookup presents a virtual address, the current 8-bit address-space identifier and the kind of access. The block returns a physical address, a flag that says whether writing is allowed, and a 3-bit code that reports a successful translation or the reason for failure.

The lookup logic is combinational across all entries, and its result is captured in output registers on the next rising clock edge. Entries are loaded one at a time through a write port addressed by index. Replacement policy, refill and address-segment decoding belong to the surrounding logic.

Top module: `pair_tlb`

## Requirements
- R1: While reset is held and after it is released, every entry is hardware-invalid, and the outputs read res_code = 1 (no match), res_paddr = 0 and res_write_ok = 0 until a lookup result replaces them.
- R2: An entry hits only when its hardware-invalid bit is clear, its masked page-pair tag equals the masked lookup address, and either its global bit is set or its stored identifier equals lk_asid.
- R3: The effective mask of an entry is its page mask ORed with 0x1FFF, so half-pages are at least 4 KB; address bits under the effective mask are left out of the tag compare. Page masks are contiguous runs of ones starting at bit 13.
- R4: The highest bit of the effective mask in the lookup address picks the half: 0 selects the even frame and attribute bits, 1 the odd ones. Attribute bits per half are [0] valid, [1] dirty, [2] read-inhibit, [3] execute-inhibit.
- R5: For the selected half the checks apply in this order: not valid gives code 2; fetch (lk_kind = 0) with execute-inhibit gives code 5; load (lk_kind = 1, or the spare value 3) with read-inhibit gives code 4; store (lk_kind = 2) with dirty clear gives code 3; otherwise code 0 (match).
- R6: On a match, res_paddr is the selected frame ORed with the lookup address bits below the select bit, and res_write_ok equals the selected dirty bit.
- R7: With no hitting entry the code is 1; on every code other than 0, res_paddr is 0 and res_write_ok is 0.
- R8: When several entries hit, the one with the lowest index decides the result.
- R9: A lookup's result appears on the outputs after the next rising edge; a write lands on that same edge, so a lookup in the write's cycle still sees the old entry and the next cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 treated as load |
| wr_en | input | 1 | Load one entry at the next edge |
| wr_idx | input | 4 | Index of the entry to load |
| wr_vpair | input | 32 | Virtual page-pair tag |
| wr_pmask | input | 32 | Page mask (contiguous ones from bit 13 up, or zero) |
| wr_asid | input | 8 | Identifier stored with the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_hwinv | input | 1 | Entry marked hardware-invalid |
| wr_pfn_even | input | 32 | Physical frame for the even half |
| wr_pfn_odd | input | 32 | Physical frame for the odd half |
| wr_attr_even | input | 4 | Even-half attributes {xi, ri, dirty, valid} |
| wr_attr_odd | input | 4 | Odd-half attributes {xi, ri, dirty, valid} |
| res_paddr | output | 32 | Translated physical address |
| res_write_ok | output | 1 | Write permitted on this translation |
| res_code | output | 3 | Result code (0 match, 1 no match, 2 invalid, 3 dirty, 4 read-inhibit, 5 execute-inhibit) |

## Verification
Every lookup result is due exactly one rising edge after its inputs are presented, so the bench drives a lookup on a falling edge, computes the expected code, address and write flag from its own entry model at that moment, and compares the outputs on the following falling edge. Writes are applied to the model only after that edge, which reproduces the rule that a lookup in the write's own cycle sees the old entry. Directed lookups cover each check in the priority order, both halves, a larger page size, identifier and global matching, hardware-invalid entries and overlapping entries, and a randomised run then compares every cycle.

// File: rtl/pair_tlb.sv
module pair_tlb #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ID_W    = 8,
  parameter int MIN_BITS = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VA_W-1:0]            lk_vaddr,
  input  logic [ID_W-1:0]            lk_asid,
  input  logic [1:0]                 lk_kind,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VA_W-1:0]            wr_vpair,
  input  logic [VA_W-1:0]            wr_pmask,
  input  logic [ID_W-1:0]            wr_asid,
  input  logic                       wr_global,
  input  logic                       wr_hwinv,
  input  logic [PA_W-1:0]            wr_pfn_even,
  input  logic [PA_W-1:0]            wr_pfn_odd,
  input  logic [3:0]                 wr_attr_even,
  input  logic [3:0]                 wr_attr_odd,
  output logic [PA_W-1:0]            res_paddr,
  output logic                       res_write_ok,
  output logic [2:0]                 res_code
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [VA_W-1:0] MIN_MASK = (VA_W'(1) << MIN_BITS) - VA_W'(1);

  localparam logic [2:0] C_MATCH = 3'd0;
  localparam logic [2:0] C_NONE  = 3'd1;
  localparam logic [2:0] C_INVAL = 3'd2;
  localparam logic [2:0] C_DIRTY = 3'd3;
  localparam logic [2:0] C_RINH  = 3'd4;
  localparam logic [2:0] C_XINH  = 3'd5;

  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_STORE = 2'd2;

  logic [VA_W-1:0] e_vpair [ENTRIES];
  logic [VA_W-1:0] e_mask  [ENTRIES];
  logic [ID_W-1:0] e_asid  [ENTRIES];
  logic            e_glob  [ENTRIES];
  logic            e_hinv  [ENTRIES];
  logic [PA_W-1:0] e_pfn0  [ENTRIES];
  logic [PA_W-1:0] e_pfn1  [ENTRIES];
  logic [3:0]      e_att0  [ENTRIES];
  logic [3:0]      e_att1  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpair[i] <= '0;
        e_mask[i]  <= '0;
        e_asid[i]  <= '0;
        e_glob[i]  <= 1'b0;
        e_hinv[i]  <= 1'b1;
        e_pfn0[i]  <= '0;
        e_pfn1[i]  <= '0;
        e_att0[i]  <= '0;
        e_att1[i]  <= '0;
      end
    end else if (wr_en) begin
      e_vpair[wr_idx] <= wr_vpair;
      e_mask[wr_idx]  <= wr_pmask | MIN_MASK;
      e_asid[wr_idx]  <= wr_asid;
      e_glob[wr_idx]  <= wr_global;
      e_hinv[wr_idx]  <= wr_hwinv;
      e_pfn0[wr_idx]  <= wr_pfn_even;
      e_pfn1[wr_idx]  <= wr_pfn_odd;
      e_att0[wr_idx]  <= wr_attr_even;
      e_att1[wr_idx]  <= wr_attr_odd;
    end
  end

  logic [ENTRIES-1:0] hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = !e_hinv[g]
                 && (((e_vpair[g] ^ lk_vaddr) & ~e_mask[g]) == '0)
                 && (e_glob[g] || (e_asid[g] == lk_asid));
  end

  logic             found;
  logic [IDX_W-1:0] win;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        win   = IDX_W'(i);
      end
    end
  end

  logic [VA_W-1:0] sel_mask;
  logic [VA_W-1:0] half_mask;
  logic            odd;
  logic [3:0]      att;
  logic [PA_W-1:0] pfn;
  logic [2:0]      code_d;

  assign sel_mask  = e_mask[win];
  assign half_mask = sel_mask >> 1;
  assign odd       = |(lk_vaddr & sel_mask & ~half_mask);
  assign att       = odd ? e_att1[win] : e_att0[win];
  assign pfn       = odd ? e_pfn1[win] : e_pfn0[win];

  always_comb begin
    if (!found)                                   code_d = C_NONE;
    else if (!att[0])                             code_d = C_INVAL;
    else if (lk_kind == K_FETCH && att[3])        code_d = C_XINH;
    else if (lk_kind != K_FETCH && lk_kind != K_STORE && att[2])
                                                  code_d = C_RINH;
    else if (lk_kind == K_STORE && !att[1])       code_d = C_DIRTY;
    else                                          code_d = C_MATCH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_code     <= C_NONE;
      res_paddr    <= '0;
      res_write_ok <= 1'b0;
    end else begin
      res_code     <= code_d;
      res_paddr    <= (code_d == C_MATCH) ? (pfn | PA_W'(lk_vaddr & half_mask)) : '0;
      res_write_ok <= (code_d == C_MATCH) && att[1];
    end
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_code <= C_XINH); // R5
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_code != C_MATCH) |-> (res_paddr == '0 && !res_write_ok)); // R7
  AST_FETCH_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind == K_FETCH) |=> (res_code != C_RINH && res_code != C_DIRTY)); // R5
  AST_LOAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind[0]) |=> (res_code != C_XINH && res_code != C_DIRTY)); // R5
  AST_STORE_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind == K_STORE) |=> (res_code == C_MATCH ? res_write_ok : res_code != C_XINH && res_code != C_RINH)); // R6
endmodule

// File: tb/test_pair_tlb.sv
`timescale 1ns/1ps
module test_pair_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_kind = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_vpair = '0, wr_pmask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0, wr_hwinv = 1'b0;
  logic [3:0]  wr_attr_even = '0, wr_attr_odd = '0;
  logic [31:0] res_paddr;
  logic        res_write_ok;
  logic [2:0]  res_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pair_tlb i_pair_tlb (
    .clk, .rst_n, .lk_vaddr, .lk_asid, .lk_kind, .wr_en, .wr_idx, .wr_vpair,
    .wr_pmask, .wr_asid, .wr_global, .wr_hwinv, .wr_pfn_even, .wr_pfn_odd,
    .wr_attr_even, .wr_attr_odd, .res_paddr, .res_write_ok, .res_code);

  logic [31:0] m_vp [16];
  logic [31:0] m_pm [16];
  logic [7:0]  m_id [16];
  logic        m_g  [16];
  logic        m_hv [16];
  logic [31:0] m_f0 [16];
  logic [31:0] m_f1 [16];
  logic [3:0]  m_a0 [16];
  logic [3:0]  m_a1 [16];

  function automatic void model(input logic [31:0] va, input logic [7:0] id, input logic [1:0] kind,
                                output logic [2:0] code, output logic [31:0] pa, output logic wok);
    int sel = -1;
    logic [31:0] m, half;
    int top = 0;
    logic [3:0] a;
    logic [31:0] f;
    logic is_odd;
    for (int i = 0; i < 16; i++) begin
      m = m_pm[i] | 32'h1FFF;
      if (sel < 0 && !m_hv[i] && ((m_vp[i] & ~m) == (va & ~m)) && (m_g[i] || m_id[i] == id))
        sel = i;
    end
    code = 3'd1; pa = '0; wok = 1'b0;
    if (sel < 0) return;
    m = m_pm[sel] | 32'h1FFF;
    for (int b = 0; b < 32; b++) if (m[b]) top = b;
    is_odd = va[top];
    half = (32'h1 << top) - 32'h1;
    a = is_odd ? m_a1[sel] : m_a0[sel];
    f = is_odd ? m_f1[sel] : m_f0[sel];
    if (!a[0]) code = 3'd2;
    else if (kind == 2'd0 && a[3]) code = 3'd5;
    else if ((kind == 2'd1 || kind == 2'd3) && a[2]) code = 3'd4;
    else if (kind == 2'd2 && !a[1]) code = 3'd3;
    else begin
      code = 3'd0; pa = f | (va & half); wok = a[1];
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_wr(input int idx, input logic [31:0] vp, input logic [31:0] pm, input logic [7:0] id,
                        input logic g, input logic hv, input logic [31:0] f0, input logic [31:0] f1,
                        input logic [3:0] a0, input logic [3:0] a1);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpair = vp; wr_pmask = pm; wr_asid = id;
    wr_global = g; wr_hwinv = hv; wr_pfn_even = f0; wr_pfn_odd = f1;
    wr_attr_even = a0; wr_attr_odd = a1;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] id, input logic [1:0] kind, input string req);
    logic [2:0] ec; logic [31:0] ep; logic ew;
    lk_vaddr = va; lk_asid = id; lk_kind = kind;
    model(va, id, kind, ec, ep, ew);
    @(posedge clk);
    if (wr_en) begin
      m_vp[wr_idx] = wr_vpair; m_pm[wr_idx] = wr_pmask; m_id[wr_idx] = wr_asid;
      m_g[wr_idx] = wr_global; m_hv[wr_idx] = wr_hwinv; m_f0[wr_idx] = wr_pfn_even;
      m_f1[wr_idx] = wr_pfn_odd; m_a0[wr_idx] = wr_attr_even; m_a1[wr_idx] = wr_attr_odd;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(req, 32'(res_code), 32'(ec), "code");
    check(req, res_paddr, ep, "paddr");
    check(req, 32'(res_write_ok), 32'(ew), "write_ok");
  endtask

  task automatic idle_write(input string req);
    look(32'hFFFF_0000, 8'h00, 2'd1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_vp[i] = '0; m_pm[i] = '0; m_id[i] = '0; m_g[i] = 1'b0; m_hv[i] = 1'b1;
      m_f0[i] = '0; m_f1[i] = '0; m_a0[i] = '0; m_a1[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1", 32'(res_code), 32'd1, "reset code");
    check("R1", res_paddr, 32'h0, "reset paddr");
    check("R1", 32'(res_write_ok), 32'd0, "reset write_ok");
    rst_n = 1'b1;
    look(32'h0000_0000, 8'h00, 2'd1, "R1");
    look(32'h0040_0123, 8'h05, 2'd0, "R1");

    // R4 R6: 4 KB pair, even half writable, odd half read-only
    set_wr(0, 32'h0040_0000, 32'h0, 8'h05, 1'b0, 1'b0, 32'h1000_0000, 32'h2000_0000, 4'b0011, 4'b0001);
    idle_write("R9");
    look(32'h0040_0123, 8'h05, 2'd1, "R6");
    look(32'h0040_1456, 8'h05, 2'd1, "R4");
    look(32'h0040_1456, 8'h05, 2'd2, "R5");
    look(32'h0040_0FFC, 8'h05, 2'd2, "R6");
    look(32'h0040_0123, 8'h06, 2'd1, "R2");
    look(32'h0040_2000, 8'h05, 2'd1, "R7");
    // R2: global entry ignores identifier; hardware-invalid never hits
    set_wr(1, 32'h0080_0000, 32'h0, 8'h33, 1'b1, 1'b0, 32'h3000_0000, 32'h3100_0000, 4'b0011, 4'b0011);
    idle_write("R2");
    look(32'h0080_0010, 8'h99, 2'd0, "R2");
    set_wr(1, 32'h0080_0000, 32'h0, 8'h33, 1'b1, 1'b1, 32'h3000_0000, 32'h3100_0000, 4'b0011, 4'b0011);
    idle_write("R2");
    look(32'h0080_0010, 8'h33, 2'd0, "R2");
    // R3: 64 KB halves
    set_wr(2, 32'h0100_0000, 32'h0001_E000, 8'h05, 1'b0, 1'b0, 32'h4000_0000, 32'h5000_0000, 4'b0011, 4'b0011);
    idle_write("R3");
    look(32'h0101_2345, 8'h05, 2'd2, "R3");
    look(32'h0100_8ABC, 8'h05, 2'd1, "R3");
    look(32'h0102_0000, 8'h05, 2'd1, "R3");
    // R5: check ordering
    set_wr(3, 32'h0200_0000, 32'h0, 8'h05, 1'b0, 1'b0, 32'h6000_0000, 32'h6100_0000, 4'b1100, 4'b1101);
    idle_write("R5");
    look(32'h0200_0004, 8'h05, 2'd0, "R5");
    look(32'h0200_1004, 8'h05, 2'd0, "R5");
    look(32'h0200_1004, 8'h05, 2'd1, "R5");
    look(32'h0200_1004, 8'h05, 2'd3, "R5");
    look(32'h0200_1004, 8'h05, 2'd2, "R5");
    // R8: overlapping entries
    set_wr(4, 32'h0300_0000, 32'h0, 8'h00, 1'b1, 1'b0, 32'h7000_0000, 32'h7000_0000, 4'b0011, 4'b0011);
    idle_write("R8");
    set_wr(5, 32'h0300_0000, 32'h0, 8'h00, 1'b1, 1'b0, 32'h7800_0000, 32'h7800_0000, 4'b0001, 4'b0001);
    idle_write("R8");
    look(32'h0300_0ABC, 8'h01, 2'd2, "R8");
    set_wr(4, 32'h0300_0000, 32'h0, 8'h00, 1'b1, 1'b1, 32'h7000_0000, 32'h7000_0000, 4'b0011, 4'b0011);
    idle_write("R8");
    look(32'h0300_0ABC, 8'h01, 2'd1, "R8");
    // R9: write and lookup in the same cycle
    set_wr(6, 32'h0400_0000, 32'h0, 8'h05, 1'b0, 1'b0, 32'h0800_0000, 32'h0900_0000, 4'b0011, 4'b0011);
    look(32'h0400_0044, 8'h05, 2'd1, "R9");
    look(32'h0400_0044, 8'h05, 2'd1, "R9");

    // randomised sweep against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] base;
      base = {6'd0, 4'($urandom_range(0, 15)), 22'd0};
      if ($urandom_range(0, 7) == 0)
        set_wr($urandom_range(0, 15), base, ($urandom_range(0, 1) != 0) ? 32'h0000_6000 : 32'h0,
               8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
               {$urandom_range(0, 255) << 24}, {$urandom_range(0, 255) << 24},
               4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
      look(base | 32'($urandom_range(0, 32'h7FFF)), 8'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule